// File: doc/BRIEF.md
# Decimal Adjust Unit

This block is the decimal arithmetic stage of a small 8-bit CPU datapath. It takes two operands, a carry-in, an add/subtract select and a decimal-mode select. It adds or subtracts them in nibble slices. In decimal mode it turns the binary outcome into packed BCD (binary-coded decimal) before the value reaches the accumulator.

During a decimal addition, each nibble slice looks for a digit above nine. The low slice then forces an extra carry into the high slice. A slice that needs adjustment adds six to its nibble, modulo 16. The high slice's adjustment also raises the carry output.

During a decimal subtraction, a slice that borrowed takes six from its nibble. No extra carry moves between the slices.

The adjustment sits after the adder, on the path to the accumulator. The negative and zero flags are taken from the value before adjustment, not from the decimal result. With decimal mode low, the unit is a plain binary adder/subtractor. All outputs are registered once.

Top module: `dadj_unit`

## Requirements
- R1: A synchronous active-high `rst` clears `sum_out`, `carry_out`, `neg_flag` and `zero_flag` to 0. Outside reset, every rising clock edge loads the outputs computed from the inputs present at that edge, a latency of one cycle.
- R2: With `dec_mode`=1, `sub_sel`=0 and both operands valid packed BCD (each nibble 0..9), take T = A + B + `carry_in`, where A and B are the operands' decimal values. Then `sum_out` is the packed BCD of T mod 100, and `carry_out` is 1 exactly when T > 99.
- R3: With `dec_mode`=1 and valid BCD operands, both nibbles of `sum_out` are at most 9, for addition and for subtraction.
- R4: With `dec_mode`=1, `sub_sel`=1 and valid BCD operands, take D = A - B - (1 - `carry_in`). Then `sum_out` is the packed BCD of D mod 100, and `carry_out` is 1 exactly when D >= 0 (no borrow).
- R5: In a decimal addition, take L = A[3:0] + B[3:0] + `carry_in` and dc = (L > 9). The pre-adjust value P has low nibble L mod 16 and high nibble (A[7:4] + B[7:4] + dc) mod 16. Then `neg_flag` = P[7] and `zero_flag` = (P == 0).
- R6: With `dec_mode`=0 and `sub_sel`=0, {`carry_out`, `sum_out`} = A + B + `carry_in` as a 9-bit binary sum. `neg_flag` = `sum_out`[7] and `zero_flag` = (`sum_out` == 0).
- R7: With `dec_mode`=0 and `sub_sel`=1, {`carry_out`, `sum_out`} = A + (~B) + `carry_in` in 9 bits. `carry_in`=1 means no borrow. The flags are taken from `sum_out` as in R6.
- R8: In a decimal subtraction no carry is injected between nibbles. The flags come from the binary value A + (~B) + `carry_in` (low 8 bits), not from the decimal result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 8 | First operand (minuend when subtracting) |
| op_b | input | 8 | Second operand (subtrahend when subtracting) |
| carry_in | input | 1 | Carry in; for subtraction 1 means no borrow |
| sub_sel | input | 1 | 0 add, 1 subtract |
| dec_mode | input | 1 | 1 selects packed BCD adjustment |
| sum_out | output | 8 | Registered result (adjusted in decimal mode) |
| carry_out | output | 1 | Registered carry, or not-borrow when subtracting |
| neg_flag | output | 1 | Registered bit 7 of the pre-adjust value |
| zero_flag | output | 1 | Registered zero test of the pre-adjust value |

## Verification
Digit adjustment and flag evaluation fall in the same cycle, and they see different values: the result is the adjusted one, while the flags come from the value before adjustment. The bench provokes the split by sweeping every pair of valid BCD operands, with both carry-in values, for addition and for subtraction. Cases like 99+01 (pre-adjust 0xAA, result 00 with carry) and 00-01 (pre-adjust 0xFF, result 99 with borrow) show a negative or non-zero flag next to a decimal result that says otherwise. Each output is judged against its own bench model: a decimal reference for the result and carry, and the pre-adjust nibble formula for the flags.

// File: rtl/dadj_pkg.sv
package dadj_pkg;

    localparam int NIB_W = 4;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_kind_t;

    // Result of one nibble slice: pre-adjust digit, adjusted digit, carry to next slice
    typedef struct packed {
        logic [NIB_W-1:0] raw;
        logic [NIB_W-1:0] adj;
        logic             cout;
    } nib_res_t;

    // Adjust a digit: +6 after a decimal overflow, -6 (i.e. +10 mod 16) after a borrow
    function automatic logic [NIB_W-1:0] fix_nibble(logic [NIB_W-1:0] v, logic up, logic down);
        logic [NIB_W-1:0] r;
        if (up)        r = v + 4'd6;
        else if (down) r = v + 4'd10;
        else           r = v;
        return r;
    endfunction

    function automatic logic is_bcd8(logic [7:0] v);
        return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9);
    endfunction

    function automatic int bcd_value(logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

endpackage

// File: rtl/dadj_slice.sv
module dadj_slice
    import dadj_pkg::*;
(
    input  logic [NIB_W-1:0] a_nib,
    input  logic [NIB_W-1:0] b_nib,
    input  logic             cin,
    input  op_kind_t         op,
    input  logic             dec,
    output nib_res_t         res
);

    logic [NIB_W-1:0] b_eff;
    logic [NIB_W:0]   s_ext;
    logic             over_nine;
    logic             fix_up;
    logic             fix_dn;

    always_comb begin
        b_eff     = (op == OP_SUB) ? ~b_nib : b_nib;
        s_ext     = {1'b0, a_nib} + {1'b0, b_eff} + {{NIB_W{1'b0}}, cin};
        over_nine = (s_ext > 5'd9);
        // addition: digit above nine needs +6 and forces a carry onward
        fix_up    = dec && (op == OP_ADD) && over_nine;
        // subtraction: digit that borrowed needs -6, carry chain left alone
        fix_dn    = dec && (op == OP_SUB) && !s_ext[NIB_W];
        res.raw   = s_ext[NIB_W-1:0];
        res.adj   = fix_nibble(s_ext[NIB_W-1:0], fix_up, fix_dn);
        res.cout  = s_ext[NIB_W] | fix_up;
    end

endmodule

// File: rtl/dadj_chain.sv
module dadj_chain
    import dadj_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  op_kind_t          op,
    input  logic              dec,
    output logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] adj,
    output logic              cout
);

    localparam int NIBS = DATA_W / NIB_W;

    logic     [NIBS:0]   carry;
    nib_res_t [NIBS-1:0] slice_res;

    assign carry[0] = cin;

    for (genvar n = 0; n < NIBS; n++) begin : g_slice
        dadj_slice u_slice (
            .a_nib (a[n*NIB_W +: NIB_W]),
            .b_nib (b[n*NIB_W +: NIB_W]),
            .cin   (carry[n]),
            .op    (op),
            .dec   (dec),
            .res   (slice_res[n])
        );
        assign carry[n+1]          = slice_res[n].cout;
        assign raw[n*NIB_W +: NIB_W] = slice_res[n].raw;
        assign adj[n*NIB_W +: NIB_W] = slice_res[n].adj;
    end

    assign cout = carry[NIBS];

endmodule

// File: rtl/dadj_unit.sv
module dadj_unit
    import dadj_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              carry_in,
    input  logic              sub_sel,
    input  logic              dec_mode,
    output logic [DATA_W-1:0] sum_out,
    output logic              carry_out,
    output logic              neg_flag,
    output logic              zero_flag
);

    op_kind_t          op;
    logic [DATA_W-1:0] pre_adj;
    logic [DATA_W-1:0] post_adj;
    logic              chain_cout;

    assign op = sub_sel ? OP_SUB : OP_ADD;

    dadj_chain #(.DATA_W(DATA_W)) u_chain (
        .a    (op_a),
        .b    (op_b),
        .cin  (carry_in),
        .op   (op),
        .dec  (dec_mode),
        .raw  (pre_adj),
        .adj  (post_adj),
        .cout (chain_cout)
    );

    // Adjusted value goes to the accumulator; flags look at the pre-adjust value
    always_ff @(posedge clk) begin
        if (rst) begin
            sum_out   <= '0;
            carry_out <= 1'b0;
            neg_flag  <= 1'b0;
            zero_flag <= 1'b0;
        end else begin
            sum_out   <= post_adj;
            carry_out <= chain_cout;
            neg_flag  <= pre_adj[DATA_W-1];
            zero_flag <= (pre_adj == '0);
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (sum_out == '0 && !carry_out && !neg_flag && !zero_flag));

    if (DATA_W == 8) begin : g_chk8
        p_binary_add_r6: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(dec_mode) && !$past(sub_sel)) |->
            ({carry_out, sum_out} ==
             {1'b0, $past(op_a)} + {1'b0, $past(op_b)} + {8'd0, $past(carry_in)}));

        p_digit_range_r3: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(dec_mode) && is_bcd8($past(op_a)) && is_bcd8($past(op_b)))
            |-> is_bcd8(sum_out));

        p_dec_add_carry_r2: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(dec_mode) && !$past(sub_sel) &&
             is_bcd8($past(op_a)) && is_bcd8($past(op_b))) |->
            (carry_out == ((bcd_value($past(op_a)) + bcd_value($past(op_b)) +
                            int'($past(carry_in))) > 99)));

        p_dec_sub_borrow_r4: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(dec_mode) && $past(sub_sel) &&
             is_bcd8($past(op_a)) && is_bcd8($past(op_b))) |->
            (carry_out == ({1'b0, $past(op_a)} >=
                           {1'b0, $past(op_b)} + {8'd0, !$past(carry_in)})));
    end

endmodule

// File: tb/dadj_unit_bench.sv
module dadj_unit_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] op_a;
    logic [7:0] op_b;
    logic       carry_in;
    logic       sub_sel;
    logic       dec_mode;
    logic [7:0] sum_out;
    logic       carry_out;
    logic       neg_flag;
    logic       zero_flag;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;  // 200 MHz

    dadj_unit u_dadj_unit (
        .clk       (clk),
        .rst       (rst),
        .op_a      (op_a),
        .op_b      (op_b),
        .carry_in  (carry_in),
        .sub_sel   (sub_sel),
        .dec_mode  (dec_mode),
        .sum_out   (sum_out),
        .carry_out (carry_out),
        .neg_flag  (neg_flag),
        .zero_flag (zero_flag)
    );

    function automatic int to_int(logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic logic [7:0] to_bcd(int n);
        return {4'(n / 10), 4'(n % 10)};
    endfunction

    task automatic cmp(input string req, input string what, input int act, input int exp);
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h (a=%h b=%h cin=%b sub=%b dec=%b)",
                     req, what, act, exp, op_a, op_b, carry_in, sub_sel, dec_mode);
        end
    endtask

    // Drive at negedge, result registered at next posedge, sample at the following negedge
    task automatic run_vec(input logic [7:0] a, input logic [7:0] b, input logic c,
                           input logic s, input logic d);
        int         t;
        logic [8:0] bin;
        logic [7:0] exp_sum;
        logic       exp_c;
        logic [7:0] pre;
        int         lo;
        logic       dc;
        @(negedge clk);
        op_a = a; op_b = b; carry_in = c; sub_sel = s; dec_mode = d;
        @(negedge clk);
        vectors++;
        bin = s ? ({1'b0, a} + {1'b0, ~b} + {8'd0, c}) : ({1'b0, a} + {1'b0, b} + {8'd0, c});
        if (!d) begin
            cmp(s ? "R7" : "R6", "sum", int'(sum_out), int'(bin[7:0]));
            cmp(s ? "R7" : "R6", "carry", int'(carry_out), int'(bin[8]));
            cmp(s ? "R7" : "R6", "neg", int'(neg_flag), int'(bin[7]));
            cmp(s ? "R7" : "R6", "zero", int'(zero_flag), int'(bin[7:0] == 8'd0));
        end else if (!s) begin
            t = to_int(a) + to_int(b) + int'(c);
            exp_c = (t > 99);
            exp_sum = to_bcd(t % 100);
            cmp("R2", "sum", int'(sum_out), int'(exp_sum));
            cmp("R2", "carry", int'(carry_out), int'(exp_c));
            cmp("R3", "digits", int'(sum_out[3:0] <= 4'd9 && sum_out[7:4] <= 4'd9), 1);
            lo = int'(a[3:0]) + int'(b[3:0]) + int'(c);
            dc = (lo > 9);
            pre[3:0] = 4'(lo);
            pre[7:4] = 4'(int'(a[7:4]) + int'(b[7:4]) + int'(dc));
            cmp("R5", "neg", int'(neg_flag), int'(pre[7]));
            cmp("R5", "zero", int'(zero_flag), int'(pre == 8'd0));
        end else begin
            t = to_int(a) - to_int(b) - (1 - int'(c));
            exp_c = (t >= 0);
            if (t < 0) t += 100;
            exp_sum = to_bcd(t);
            cmp("R4", "sum", int'(sum_out), int'(exp_sum));
            cmp("R4", "carry", int'(carry_out), int'(exp_c));
            cmp("R3", "digits", int'(sum_out[3:0] <= 4'd9 && sum_out[7:4] <= 4'd9), 1);
            cmp("R8", "neg", int'(neg_flag), int'(bin[7]));
            cmp("R8", "zero", int'(zero_flag), int'(bin[7:0] == 8'd0));
        end
    endtask

    initial begin
        int unsigned seed_set;
        seed_set = $urandom(32'd4711);
        rst = 1'b1; op_a = 8'h99; op_b = 8'h99; carry_in = 1'b1; sub_sel = 1'b0; dec_mode = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        vectors++;
        cmp("R1", "sum", int'(sum_out), 0);
        cmp("R1", "carry", int'(carry_out), 0);
        cmp("R1", "neg", int'(neg_flag), 0);
        cmp("R1", "zero", int'(zero_flag), 0);
        rst = 1'b0;

        // Directed corners: flags disagree with the decimal result
        run_vec(8'h99, 8'h01, 1'b0, 1'b0, 1'b1); // R5 pre 0xAA, R2 result 00 carry
        run_vec(8'h50, 8'h50, 1'b0, 1'b0, 1'b1); // R5 pre 0xA0
        run_vec(8'h05, 8'h05, 1'b0, 1'b0, 1'b1); // R2 low-digit carry into high digit
        run_vec(8'h00, 8'h01, 1'b1, 1'b1, 1'b1); // R4 wrap to 99, R8 pre 0xFF
        run_vec(8'h00, 8'h00, 1'b0, 1'b1, 1'b1); // R4 borrow-in only
        run_vec(8'hFF, 8'h01, 1'b0, 1'b0, 1'b0); // R6 zero with carry
        run_vec(8'h00, 8'h01, 1'b1, 1'b1, 1'b0); // R7 borrow

        // Exhaustive valid-BCD sweep
        for (int s = 0; s < 2; s++)
            for (int c = 0; c < 2; c++)
                for (int a = 0; a < 100; a++)
                    for (int b = 0; b < 100; b++)
                        run_vec(to_bcd(a), to_bcd(b), 1'(c), 1'(s), 1'b1);

        // Random binary-mode vectors
        for (int i = 0; i < 3000; i++)
            run_vec(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), 1'b0);

        // Reset again mid-run (R1)
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        vectors++;
        cmp("R1", "sum", int'(sum_out), 0);
        cmp("R1", "carry", int'(carry_out), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule